// File: doc/BRIEF.md
# Multiplexed External SRAM Bus Controller

This block sits between a core's data-space port and an external asynchronous SRAM whose low address byte and data byte share one set of pins. The requester offers a byte access on a valid/ready port. The block decodes the address. A location at or below 0x025F, or any location while the interface is switched off, is treated as on-chip. Such an access is accepted in one cycle and the external pins do not move. Any higher location starts an external bus cycle.

An external cycle has an address phase and a strobe phase. In the address phase the high address byte goes out on its own port, the low address byte goes on the shared bus, and an address-latch pulse marks it. In the strobe phase the shared bus carries the data byte under an active-low read or write strobe. A wait-state setting adds a second strobe cycle. Read data returns on a one-cycle response pulse.

Back-pressure follows valid/ready rules. A request transfers on a cycle where `req_valid` and `req_ready` are both high. The requester must hold its request stable until that cycle. While an external cycle is in flight, `req_ready` is low, so only one access is ever outstanding. `busy` is a plain stall hint for a requester that cannot look at `req_ready`. The read response has no ready signal, so the requester must take `rsp_valid` in the cycle it is high.

Top module: `xmb_ctrl`

## Requirements
- R1: During and straight after reset, `ext_rd_n` and `ext_wr_n` are 1, `ext_ale` and `ext_ad_oe` are 0, `req_ready` is 1 and `rsp_valid` is 0.
- R2: An accepted request is on-chip if its address is at most 0x025F or `cfg_enable` is 0. In the following cycle `ext_ale` is 0, both strobes are 1, and `req_ready` is still 1.
- R3: In the cycle after an external request is accepted, `ext_ale` is 1, `ext_ad_oe` is 1, `ext_ad_out` holds address bits 7:0 and `ext_ah` holds address bits 15:8. `ext_ah` keeps that value through every strobe cycle of the access.
- R4: In the cycle after the address phase, `ext_ale` is 0. `ext_rd_n` is 0 for a read (`req_write`=0) and `ext_wr_n` is 0 for a write (`req_write`=1). The two strobes are never low together.
- R5: With the wait setting off, the strobe is low for one cycle and `req_ready` is 1 again three cycles after the acceptance cycle. With the wait setting on, the strobe is low for two cycles and `req_ready` returns after four cycles.
- R6: For a read, `ext_ad_in` is sampled in the last strobe cycle. In the next cycle `rsp_valid` is 1 for exactly one cycle, with that byte on `rsp_rdata`. A write raises no `rsp_valid`.
- R7: During a write strobe, `ext_ad_oe` is 1 and `ext_ad_out` equals the write byte. During a read strobe and in idle cycles, `ext_ad_oe` is 0.
- R8: `busy` is 1 in the acceptance cycle of an external request and in every later cycle of that access except the last strobe cycle. It is 0 for an on-chip request.
- R9: `pin_override` equals `cfg_enable`.
- R10: `req_ready` is 0 from the address phase through the last strobe cycle, and a request held during that time is not taken. `req_addr`, `req_write`, `req_wdata` and `cfg_wait` are sampled only in the acceptance cycle.
- R11: Address 0x025F is on-chip. Addresses 0x0260 and 0xFFFF are external.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cfg_enable | input | 1 | Turns the external interface on |
| cfg_wait | input | 1 | Adds one wait cycle to each external access |
| req_valid | input | 1 | Request offered |
| req_ready | output | 1 | Request can be accepted this cycle |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | 16 | Data-space byte address |
| req_wdata | input | 8 | Write byte |
| rsp_valid | output | 1 | One-cycle read-data pulse |
| rsp_rdata | output | 8 | Read byte |
| busy | output | 1 | Stall hint for the requester |
| ext_ah | output | 8 | High address byte |
| ext_ad_out | output | 8 | Shared bus, outgoing value |
| ext_ad_oe | output | 1 | Shared bus output enable |
| ext_ad_in | input | 8 | Shared bus, incoming value |
| ext_ale | output | 1 | Address-latch pulse |
| ext_rd_n | output | 1 | Read strobe, active low |
| ext_wr_n | output | 1 | Write strobe, active low |
| pin_override | output | 1 | Pins taken from normal port control |

## Verification
All checks are made at timestamps measured from the acceptance cycle. `busy` and `req_ready` respond combinationally in the acceptance cycle itself. The address phase is due one cycle later and the first strobe cycle two cycles later. Without wait, the response and the return of `req_ready` are due three cycles later; with wait they are due four cycles later. The bench drives inputs on the falling edge and checks each result one nanosecond later, in exactly the cycle predicted. The bench changes `ext_ad_in` in every cycle except the last strobe cycle, so a capture taken one cycle early or late returns the wrong byte.

// File: rtl/xmb_pkg.sv
package xmb_pkg;
  typedef enum logic [1:0] {
    PH_IDLE = 2'd0,
    PH_ADDR = 2'd1,
    PH_STB  = 2'd2,
    PH_WAIT = 2'd3
  } xmb_phase_e;
endpackage

// File: rtl/xmb_decode.sv
module xmb_decode #(
  parameter int ADDR_W   = 16,
  parameter int INT_LAST = 32'h025F
) (
  input  logic              enable,
  input  logic [ADDR_W-1:0] addr,
  output logic              ext_hit
);
  localparam logic [ADDR_W-1:0] LAST = INT_LAST[ADDR_W-1:0];

  always_comb ext_hit = enable && (addr > LAST);
endmodule

// File: rtl/xmb_seq.sv
module xmb_seq #(
  parameter int DATA_W = 8,
  parameter int ADDR_W = 16
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                req_valid,
  input  logic                req_write,
  input  logic [ADDR_W-1:0]   req_addr,
  input  logic [DATA_W-1:0]   req_wdata,
  input  logic                cfg_wait,
  input  logic                ext_hit,
  input  logic [DATA_W-1:0]   ext_ad_in,
  output logic                req_ready,
  output logic                busy,
  output xmb_pkg::xmb_phase_e phase,
  output logic                lat_write,
  output logic [ADDR_W-1:0]   lat_addr,
  output logic [DATA_W-1:0]   lat_wdata,
  output logic                rsp_valid,
  output logic [DATA_W-1:0]   rsp_rdata
);
  import xmb_pkg::*;

  xmb_phase_e phase_q, phase_d;
  logic       wait_q;
  logic       accept, launch, last_stb;

  always_comb begin
    accept   = req_valid && (phase_q == PH_IDLE);
    launch   = accept && ext_hit;
    last_stb = ((phase_q == PH_STB) && !wait_q) || (phase_q == PH_WAIT);
    unique case (phase_q)
      PH_IDLE: phase_d = launch ? PH_ADDR : PH_IDLE;
      PH_ADDR: phase_d = PH_STB;
      PH_STB:  phase_d = wait_q ? PH_WAIT : PH_IDLE;
      default: phase_d = PH_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      phase_q   <= PH_IDLE;
      wait_q    <= 1'b0;
      lat_write <= 1'b0;
      lat_addr  <= '0;
      lat_wdata <= '0;
      rsp_valid <= 1'b0;
      rsp_rdata <= '0;
    end else begin
      phase_q   <= phase_d;
      rsp_valid <= last_stb && !lat_write;
      if (launch) begin
        wait_q    <= cfg_wait;
        lat_write <= req_write;
        lat_addr  <= req_addr;
        lat_wdata <= req_wdata;
      end
      if (last_stb && !lat_write) rsp_rdata <= ext_ad_in;
    end
  end

  always_comb begin
    phase     = phase_q;
    req_ready = (phase_q == PH_IDLE);
    busy      = launch || (phase_q == PH_ADDR) || ((phase_q == PH_STB) && wait_q);
  end

  AST_LOCAL_STAYS_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    (accept && !ext_hit) |=> req_ready);  // R2
  AST_RSP_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid |=> !rsp_valid);  // R6
  AST_NO_SECOND_ACCEPT: assert property (@(posedge clk) disable iff (!rst_n)
    launch |=> !req_ready);  // R10
endmodule

// File: rtl/xmb_pins.sv
module xmb_pins #(
  parameter int DATA_W = 8,
  parameter int ADDR_W = 16
) (
  input  logic                clk,
  input  logic                rst_n,
  input  xmb_pkg::xmb_phase_e phase,
  input  logic                lat_write,
  input  logic [ADDR_W-1:0]   lat_addr,
  input  logic [DATA_W-1:0]   lat_wdata,
  output logic [DATA_W-1:0]   ext_ah,
  output logic [DATA_W-1:0]   ext_ad_out,
  output logic                ext_ad_oe,
  output logic                ext_ale,
  output logic                ext_rd_n,
  output logic                ext_wr_n
);
  import xmb_pkg::*;

  logic in_addr, in_stb;

  always_comb begin
    in_addr    = (phase == PH_ADDR);
    in_stb     = (phase == PH_STB) || (phase == PH_WAIT);
    ext_ale    = in_addr;
    ext_ah     = (in_addr || in_stb) ? lat_addr[ADDR_W-1 -: DATA_W] : '0;
    ext_rd_n   = !(in_stb && !lat_write);
    ext_wr_n   = !(in_stb && lat_write);
    ext_ad_oe  = in_addr || (in_stb && lat_write);
    if (in_addr)                    ext_ad_out = lat_addr[DATA_W-1:0];
    else if (in_stb && lat_write)   ext_ad_out = lat_wdata;
    else                            ext_ad_out = '0;
  end

  AST_ONE_STROBE: assert property (@(posedge clk) disable iff (!rst_n)
    !(!ext_rd_n && !ext_wr_n));  // R4
  AST_LATCH_THEN_STROBE: assert property (@(posedge clk) disable iff (!rst_n)
    ext_ale |=> (!ext_rd_n || !ext_wr_n));  // R4
  AST_BUS_DRIVE_WRITE_ONLY: assert property (@(posedge clk) disable iff (!rst_n)
    (ext_ad_oe && !ext_ale) |-> !ext_wr_n);  // R7
  AST_HIGH_BYTE_HELD: assert property (@(posedge clk) disable iff (!rst_n)
    (!ext_rd_n || !ext_wr_n) |-> $stable(ext_ah));  // R3
endmodule

// File: rtl/xmb_ctrl.sv
module xmb_ctrl #(
  parameter int DATA_W   = 8,
  parameter int INT_LAST = 32'h025F
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 cfg_enable,
  input  logic                 cfg_wait,
  input  logic                 req_valid,
  output logic                 req_ready,
  input  logic                 req_write,
  input  logic [2*DATA_W-1:0]  req_addr,
  input  logic [DATA_W-1:0]    req_wdata,
  output logic                 rsp_valid,
  output logic [DATA_W-1:0]    rsp_rdata,
  output logic                 busy,
  output logic [DATA_W-1:0]    ext_ah,
  output logic [DATA_W-1:0]    ext_ad_out,
  output logic                 ext_ad_oe,
  input  logic [DATA_W-1:0]    ext_ad_in,
  output logic                 ext_ale,
  output logic                 ext_rd_n,
  output logic                 ext_wr_n,
  output logic                 pin_override
);
  localparam int ADDR_W = 2 * DATA_W;

  logic                ext_hit;
  xmb_pkg::xmb_phase_e phase;
  logic                lat_write;
  logic [ADDR_W-1:0]   lat_addr;
  logic [DATA_W-1:0]   lat_wdata;

  xmb_decode #(.ADDR_W(ADDR_W), .INT_LAST(INT_LAST)) u_dec (
    .enable (cfg_enable),
    .addr   (req_addr),
    .ext_hit(ext_hit)
  );

  xmb_seq #(.DATA_W(DATA_W), .ADDR_W(ADDR_W)) u_seq (
    .clk      (clk),
    .rst_n    (rst_n),
    .req_valid(req_valid),
    .req_write(req_write),
    .req_addr (req_addr),
    .req_wdata(req_wdata),
    .cfg_wait (cfg_wait),
    .ext_hit  (ext_hit),
    .ext_ad_in(ext_ad_in),
    .req_ready(req_ready),
    .busy     (busy),
    .phase    (phase),
    .lat_write(lat_write),
    .lat_addr (lat_addr),
    .lat_wdata(lat_wdata),
    .rsp_valid(rsp_valid),
    .rsp_rdata(rsp_rdata)
  );

  xmb_pins #(.DATA_W(DATA_W), .ADDR_W(ADDR_W)) u_pins (
    .clk       (clk),
    .rst_n     (rst_n),
    .phase     (phase),
    .lat_write (lat_write),
    .lat_addr  (lat_addr),
    .lat_wdata (lat_wdata),
    .ext_ah    (ext_ah),
    .ext_ad_out(ext_ad_out),
    .ext_ad_oe (ext_ad_oe),
    .ext_ale   (ext_ale),
    .ext_rd_n  (ext_rd_n),
    .ext_wr_n  (ext_wr_n)
  );

  always_comb pin_override = cfg_enable;

  AST_WRITE_NO_RESPONSE: assert property (@(posedge clk) disable iff (!rst_n)
    (!ext_wr_n && ext_rd_n && !busy) |=> !rsp_valid);  // R6
endmodule

// File: tb/sim_xmb_ctrl.sv
`timescale 1ns/100ps
module sim_xmb_ctrl;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cfg_enable = 1'b0, cfg_wait = 1'b0;
  logic        req_valid = 1'b0, req_write = 1'b0;
  logic [15:0] req_addr = '0;
  logic [7:0]  req_wdata = '0, ext_ad_in = '0;
  logic        req_ready, rsp_valid, busy, ext_ad_oe, ext_ale, ext_rd_n, ext_wr_n, pin_override;
  logic [7:0]  rsp_rdata, ext_ah, ext_ad_out;
  int          checks = 0, failures = 0, cycles = 0;

  xmb_ctrl u0 (.*);

  always #2 clk = ~clk;

  always @(posedge clk) begin
    cycles++;
    if (cycles == 150000) begin
      failures++;
      $display("FAIL watchdog act=%0d exp=done", cycles);
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s act=%0h exp=%0h", tag, act, exp);
    end
  endtask

  function automatic bit exp_ext(input logic [15:0] a, input bit en);
    return en && (a > 16'h025F);
  endfunction

  task automatic run(input logic [15:0] a, input bit wr, input logic [7:0] wd,
                     input bit en, input bit wt, input logic [7:0] rdv, input bit hold_in);
    bit ext, hold;
    @(negedge clk);
    chk("R6 rsp pulse width", rsp_valid, 0);
    cfg_enable = en; cfg_wait = wt; req_valid = 1; req_write = wr;
    req_addr = a; req_wdata = wd; ext_ad_in = ~rdv;
    ext  = exp_ext(a, en);
    hold = hold_in && ext;
    #1;
    chk("R10 ready idle", req_ready, 1);
    chk("R8 busy accept", busy, ext);
    chk("R9 override", pin_override, en);
    @(negedge clk);
    if (hold) begin
      req_addr = 16'($urandom); req_write = ~wr; req_wdata = ~wd; cfg_wait = ~wt;
    end else req_valid = 0;
    ext_ad_in = 8'($urandom);
    #1;
    if (!ext) begin
      chk("R2 ale", ext_ale, 0);
      chk("R2 rd_n", ext_rd_n, 1);
      chk("R2 wr_n", ext_wr_n, 1);
      chk("R2 ready", req_ready, 1);
      return;
    end
    chk("R3 ale", ext_ale, 1);
    chk("R3 oe", ext_ad_oe, 1);
    chk("R3 low addr", ext_ad_out, a[7:0]);
    chk("R3 high addr", ext_ah, a[15:8]);
    chk("R10 ready addr", req_ready, 0);
    chk("R8 busy addr", busy, 1);
    @(negedge clk);
    if (!wt) begin ext_ad_in = rdv; req_valid = 0; end
    else ext_ad_in = ~rdv;
    #1;
    chk("R4 ale low", ext_ale, 0);
    chk("R4 rd_n", ext_rd_n, wr);
    chk("R4 wr_n", ext_wr_n, !wr);
    chk("R3 high held", ext_ah, a[15:8]);
    chk("R7 oe strobe", ext_ad_oe, wr);
    if (wr) chk("R7 wdata", ext_ad_out, wd);
    chk("R8 busy strobe", busy, wt);
    chk("R10 ready strobe", req_ready, 0);
    if (wt) begin
      @(negedge clk);
      ext_ad_in = rdv; req_valid = 0;
      #1;
      chk("R5 wait rd_n", ext_rd_n, wr);
      chk("R5 wait wr_n", ext_wr_n, !wr);
      chk("R3 high wait", ext_ah, a[15:8]);
      chk("R8 busy wait", busy, 0);
      chk("R7 oe wait", ext_ad_oe, wr);
    end
    @(negedge clk);
    ext_ad_in = 8'($urandom);
    #1;
    chk("R5 ready back", req_ready, 1);
    chk("R5 strobes off", {ext_rd_n, ext_wr_n}, 2'b11);
    chk("R7 oe idle", ext_ad_oe, 0);
    chk("R6 rsp valid", rsp_valid, !wr);
    if (!wr) chk("R6 rsp data", rsp_rdata, rdv);
  endtask

  initial begin
    void'($urandom(32'd7331));
    repeat (3) @(negedge clk);
    #1;
    chk("R1 rd_n", ext_rd_n, 1);
    chk("R1 wr_n", ext_wr_n, 1);
    chk("R1 ale", ext_ale, 0);
    chk("R1 oe", ext_ad_oe, 0);
    chk("R1 ready", req_ready, 1);
    chk("R1 rsp", rsp_valid, 0);
    rst_n = 1;
    // R11 boundary addresses
    run(16'h025F, 0, 8'h00, 1, 0, 8'h11, 0);
    run(16'h0260, 0, 8'h00, 1, 0, 8'hA5, 0);
    run(16'hFFFF, 1, 8'h3C, 1, 1, 8'h00, 0);
    run(16'hFFFF, 0, 8'h00, 1, 1, 8'h5A, 1);
    run(16'h8000, 0, 8'h00, 0, 0, 8'h77, 0);   // R2 disabled
    run(16'h1234, 1, 8'hC3, 1, 0, 8'h00, 1);   // R10 held request
    for (int i = 0; i < 400; i++) begin
      logic [15:0] a;
      case ($urandom % 3)
        0: a = 16'h025D + 16'($urandom % 6);
        1: a = 16'($urandom % 16'h0300);
        default: a = 16'($urandom);
      endcase
      run(a, 1'($urandom), 8'($urandom), ($urandom % 5) != 0,
          1'($urandom), 8'($urandom), 1'($urandom));
    end
    @(negedge clk);
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule